// File: doc/BRIEF.md
# Periodic Parallel ADC Conversion Sequencer

This block runs a 12-bit successive-approximation converter whose result comes out on a parallel bus and whose control pins behave like those of a memory device. The converter's byte-select input is strapped for full-width output, so every result arrives in a single parallel read. The converter makes a new conversion only when its chip-select and read strobes are toggled. If the strobes are held low permanently, it converts once after power-up and never again. The sequencer therefore pulls both strobes low together at a fixed rate set by its own timer. It keeps them low for the conversion time plus a settle allowance, captures the bus word, then raises the strobes and holds them high for a recovery gap before any further cycle.

The data lines may cross an isolation barrier and have no timing relation to the system clock. They pass through a synchroniser, and the capture waits long enough after the word becomes valid that the synchronised copy is fresh. Each captured word appears on a registered output with a one-cycle valid pulse and stays there until the next capture. An enable input gates new conversions. At the default values (100 MHz clock, 333-cycle period) the rate is about 300k samples per second.

Top module: `adc_strobe_seq`

## Requirements
- R1: While the synchronous active-high reset is asserted and on the first cycle after it, both strobes are high (inactive), the result output is zero and the valid pulse is low. The sample timer restarts from zero, so its first tick comes PERIOD_CYC cycles after reset is released.
- R2: The read strobe and the chip-select strobe fall together and rise together on every conversion.
- R3: Each strobe-low window lasts exactly CONV_CYC + SETTLE_CYC clock cycles.
- R4: When PERIOD_CYC is at least CONV_CYC + SETTLE_CYC + RECOV_CYC + 1 and enable stays high, the strobes fall once every PERIOD_CYC cycles. Each fall comes one cycle after a timer tick.
- R5: Between two strobe-low windows the strobes stay high for at least RECOV_CYC + 1 cycles. A tick that arrives while a cycle is in progress defers the start to the first idle cycle, and several such ticks merge into one start.
- R6: On the first high cycle after each low window, the valid output is high for exactly one cycle. The result output then carries the word the converter drove on the bus from the CONV_CYC-th low cycle onward. Bus contents earlier in the window do not affect it.
- R7: The result output keeps its value on every cycle in which valid is low.
- R8: While enable is low, no new strobe-low window starts, and timer ticks seen during that time are discarded. A window already in progress when enable falls runs to completion and still delivers its valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Allows new conversions to start |
| adc_d | input | DATA_W | Parallel result bus from the converter, asynchronous |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| sample_o | output | DATA_W | Last captured result |
| sample_vld | output | 1 | One-cycle pulse marking a new result |

## Verification
Two instances run in parallel: one with a period well above the cycle length and one with a period shorter than it. The first shows the timer sets the rate; the second shows deferral, tick merging and the recovery gap. The converter stub drives the inverse of each result during the first part of the low window, so any capture made too early or from a stale synchroniser stage produces the wrong word. Enable is held low from reset, dropped in the middle of a low window and raised again, which separates "ticks discarded" from "cycle in progress finishes". A reset in the middle of the run checks that the timer restarts.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE    = 2'd0,
      SEQ_CONVERT = 2'd1,
      SEQ_RECOVER = 2'd2
   } seq_state_t;

   function automatic int cnt_width(input int max_count);
      return (max_count > 1) ? $clog2(max_count) : 1;
   endfunction

endpackage

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
   parameter int PERIOD_CYC = 333
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   localparam int TW = adc_seq_pkg::cnt_width(PERIOD_CYC);
   localparam logic [TW-1:0] LAST = TW'(PERIOD_CYC - 1);

   logic [TW-1:0] count_q;

   always_ff @(posedge clk) begin
      if (rst)
         count_q <= '0;
      else if (count_q == LAST)
         count_q <= '0;
      else
         count_q <= count_q + 1'b1;
   end

   assign tick_o = (count_q == LAST);

endmodule

// File: rtl/adc_bus_sync.sv
module adc_bus_sync #(
   parameter int DATA_W = 12,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);
   logic [DATA_W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stage_q[0] <= '0;
               else     stage_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) stage_q[s] <= '0;
               else     stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/adc_strobe_fsm.sv
module adc_strobe_fsm
   import adc_seq_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter int LOW_CYC   = 274,
   parameter int RECOV_CYC = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enable,
   input  logic              tick,
   input  logic [DATA_W-1:0] bus_sync,
   output logic              strobe_n,
   output logic [DATA_W-1:0] sample_o,
   output logic              sample_vld
);
   localparam int CMAX = (LOW_CYC > RECOV_CYC) ? LOW_CYC : RECOV_CYC;
   localparam int CW   = cnt_width(CMAX + 1);
   localparam logic [CW-1:0] LOW_LAST   = CW'(LOW_CYC - 1);
   localparam logic [CW-1:0] RECOV_LAST = CW'(RECOV_CYC - 1);

   seq_state_t state_q;
   logic [CW-1:0] cnt_q;
   logic pending_q;
   logic start;

   assign start = (state_q == SEQ_IDLE) && pending_q && enable;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= SEQ_IDLE;
         cnt_q      <= '0;
         pending_q  <= 1'b0;
         strobe_n   <= 1'b1;
         sample_o   <= '0;
         sample_vld <= 1'b0;
      end else begin
         sample_vld <= 1'b0;
         pending_q  <= enable && ((pending_q && !start) || tick);
         case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q  <= SEQ_CONVERT;
                  cnt_q    <= '0;
                  strobe_n <= 1'b0;
               end
            end
            SEQ_CONVERT: begin
               if (cnt_q == LOW_LAST) begin
                  state_q    <= SEQ_RECOVER;
                  cnt_q      <= '0;
                  strobe_n   <= 1'b1;
                  sample_o   <= bus_sync;
                  sample_vld <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            SEQ_RECOVER: begin
               if (cnt_q == RECOV_LAST) begin
                  state_q <= SEQ_IDLE;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               state_q  <= SEQ_IDLE;
               cnt_q    <= '0;
               strobe_n <= 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/adc_strobe_seq.sv
module adc_strobe_seq #(
   parameter int DATA_W      = 12,
   parameter int SYNC_STAGES = 2,
   parameter int CONV_CYC    = 270,
   parameter int SETTLE_CYC  = 4,
   parameter int RECOV_CYC   = 20,
   parameter int PERIOD_CYC  = 333
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enable,
   input  logic [DATA_W-1:0] adc_d,
   output logic              adc_cs_n,
   output logic              adc_rd_n,
   output logic [DATA_W-1:0] sample_o,
   output logic              sample_vld
);
   localparam int LOW_CYC = CONV_CYC + SETTLE_CYC;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (SETTLE_CYC < SYNC_STAGES + 1) begin : g_bad_settle
         $error("SETTLE_CYC must exceed SYNC_STAGES");
      end
      if (CONV_CYC < 1 || RECOV_CYC < 1) begin : g_bad_timing
         $error("CONV_CYC and RECOV_CYC must be at least 1");
      end
      if (PERIOD_CYC < 2) begin : g_bad_period
         $error("PERIOD_CYC must be at least 2");
      end
   endgenerate

   logic tick;
   logic [DATA_W-1:0] bus_sync;
   logic strobe_n;

   adc_rate_timer #(
      .PERIOD_CYC(PERIOD_CYC)
   ) i_timer (
      .clk   (clk),
      .rst   (rst),
      .tick_o(tick)
   );

   adc_bus_sync #(
      .DATA_W(DATA_W),
      .STAGES(SYNC_STAGES)
   ) i_sync (
      .clk(clk),
      .rst(rst),
      .d_i(adc_d),
      .q_o(bus_sync)
   );

   adc_strobe_fsm #(
      .DATA_W   (DATA_W),
      .LOW_CYC  (LOW_CYC),
      .RECOV_CYC(RECOV_CYC)
   ) i_fsm (
      .clk       (clk),
      .rst       (rst),
      .enable    (enable),
      .tick      (tick),
      .bus_sync  (bus_sync),
      .strobe_n  (strobe_n),
      .sample_o  (sample_o),
      .sample_vld(sample_vld)
   );

   assign adc_cs_n = strobe_n;
   assign adc_rd_n = strobe_n;

endmodule

// File: rtl/adc_strobe_seq_chk.sv
module adc_strobe_seq_chk #(
   parameter int DATA_W    = 12,
   parameter int LOW_CYC   = 274,
   parameter int RECOV_CYC = 20
) (
   input logic              clk,
   input logic              rst,
   input logic              enable,
   input logic              cs_n,
   input logic              rd_n,
   input logic              sample_vld,
   input logic [DATA_W-1:0] sample_o
);
   int low_run;
   int high_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         low_run  <= 0;
         high_run <= RECOV_CYC + 1;
      end else begin
         low_run  <= cs_n ? 0 : low_run + 1;
         high_run <= cs_n ? high_run + 1 : 0;
      end
   end

   AST_LOW_WINDOW_LEN: assert property (@(posedge clk) disable iff (rst)
      $rose(cs_n) |-> (low_run == LOW_CYC)); // R3

   AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (rst)
      $fell(cs_n) |-> (high_run >= RECOV_CYC + 1)); // R5

   AST_VALID_ON_RISE: assert property (@(posedge clk) disable iff (rst)
      $rose(cs_n) |-> sample_vld); // R6

   AST_VALID_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
      sample_vld |-> $rose(cs_n)); // R6

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !sample_vld |-> $stable(sample_o)); // R7

   AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst)
      $fell(rd_n) |-> $past(enable)); // R8

endmodule

bind adc_strobe_seq adc_strobe_seq_chk #(
   .DATA_W   (DATA_W),
   .LOW_CYC  (CONV_CYC + SETTLE_CYC),
   .RECOV_CYC(RECOV_CYC)
) i_chk (
   .clk       (clk),
   .rst       (rst),
   .enable    (enable),
   .cs_n      (adc_cs_n),
   .rd_n      (adc_rd_n),
   .sample_vld(sample_vld),
   .sample_o  (sample_o)
);

// File: tb/test_adc_strobe_seq.sv
module adc_conv_stub #(
   parameter int CONV_CYC = 10
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        cs_n,
   output logic [11:0] d
);
   int falls;
   int lc;
   int cur;

   function automatic logic [11:0] word_of(input int k);
      return 12'((k * 935 + 21) & 12'hfff);
   endfunction

   initial begin
      falls = 0; lc = 0; cur = 0; d = '0;
   end

   always @(negedge clk) begin
      if (rst) begin
         falls = 0; lc = 0; d = '0;
      end else if (!cs_n) begin
         if (lc == 0) begin
            cur = falls;
            falls++;
            d = ~word_of(cur);
         end
         lc++;
         if (lc == CONV_CYC + 1) d = word_of(cur);
      end else begin
         lc = 0;
      end
   end
endmodule

module adc_seq_ref #(
   parameter int LOW_CYC    = 14,
   parameter int RECOV_CYC  = 6,
   parameter int PERIOD_CYC = 40
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        enable,
   output logic        exp_cs_n,
   output logic        exp_vld,
   output logic [11:0] exp_data
);
   int tcnt, phase, cnt, k;
   bit pend, tk, st;

   function automatic logic [11:0] word_of(input int n);
      return 12'((n * 935 + 21) & 12'hfff);
   endfunction

   initial begin
      tcnt = 0; phase = 0; cnt = 0; k = 0; pend = 0;
      exp_cs_n = 1; exp_vld = 0; exp_data = '0;
   end

   always @(posedge clk) begin
      if (rst) begin
         tcnt = 0; phase = 0; cnt = 0; k = 0; pend = 0;
         exp_cs_n = 1; exp_vld = 0; exp_data = '0;
      end else begin
         tk = (tcnt == PERIOD_CYC - 1);
         st = (phase == 0) && pend && enable;
         tcnt = tk ? 0 : tcnt + 1;
         exp_vld = 0;
         if (phase == 0) begin
            if (st) begin phase = 1; cnt = 0; end
         end else if (phase == 1) begin
            if (cnt == LOW_CYC - 1) begin
               phase = 2; cnt = 0; exp_vld = 1;
               exp_data = word_of(k); k++;
            end else cnt++;
         end else begin
            if (cnt == RECOV_CYC - 1) begin phase = 0; cnt = 0; end
            else cnt++;
         end
         pend = enable && ((pend && !st) || tk);
         exp_cs_n = (phase != 1);
      end
   end
endmodule

module test_adc_strobe_seq;
   localparam int CONV   = 10;
   localparam int SETTLE = 4;
   localparam int RECOV  = 6;
   localparam int LOWC   = CONV + SETTLE;
   localparam int SLOW_P = 40;
   localparam int FAST_P = 12;

   logic clk = 0;
   logic rst = 1;
   logic enable = 0;
   always #5 clk = ~clk;

   logic [11:0] d_s, d_f, so_s, so_f, ed_s, ed_f;
   logic cs_s, rd_s, v_s, cs_f, rd_f, v_f, ecs_s, ev_s, ecs_f, ev_f;

   int n_cmp = 0;
   int n_bad = 0;
   bit armed = 0;
   int cyc = 0;

   adc_strobe_seq #(.DATA_W(12), .SYNC_STAGES(2), .CONV_CYC(CONV), .SETTLE_CYC(SETTLE),
                    .RECOV_CYC(RECOV), .PERIOD_CYC(SLOW_P)) i_adc_strobe_seq (
      .clk(clk), .rst(rst), .enable(enable), .adc_d(d_s),
      .adc_cs_n(cs_s), .adc_rd_n(rd_s), .sample_o(so_s), .sample_vld(v_s));

   adc_strobe_seq #(.DATA_W(12), .SYNC_STAGES(2), .CONV_CYC(CONV), .SETTLE_CYC(SETTLE),
                    .RECOV_CYC(RECOV), .PERIOD_CYC(FAST_P)) i_adc_strobe_seq_fast (
      .clk(clk), .rst(rst), .enable(enable), .adc_d(d_f),
      .adc_cs_n(cs_f), .adc_rd_n(rd_f), .sample_o(so_f), .sample_vld(v_f));

   adc_conv_stub #(.CONV_CYC(CONV)) i_stub_s (.clk(clk), .rst(rst), .cs_n(cs_s), .d(d_s));
   adc_conv_stub #(.CONV_CYC(CONV)) i_stub_f (.clk(clk), .rst(rst), .cs_n(cs_f), .d(d_f));

   adc_seq_ref #(.LOW_CYC(LOWC), .RECOV_CYC(RECOV), .PERIOD_CYC(SLOW_P)) i_ref_s (
      .clk(clk), .rst(rst), .enable(enable), .exp_cs_n(ecs_s), .exp_vld(ev_s), .exp_data(ed_s));
   adc_seq_ref #(.LOW_CYC(LOWC), .RECOV_CYC(RECOV), .PERIOD_CYC(FAST_P)) i_ref_f (
      .clk(clk), .rst(rst), .enable(enable), .exp_cs_n(ecs_f), .exp_vld(ev_f), .exp_data(ed_f));

   task automatic check(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // per-clock comparison against the reference model
   always @(negedge clk) begin
      cyc++;
      if (armed) begin
         check("R3", "slow cs_n", cs_s, ecs_s);
         check("R2", "slow rd_n", rd_s, ecs_s);
         check("R6", "slow valid", v_s, ev_s);
         check("R7", "slow result", so_s, ed_s);
         check("R5", "fast cs_n", cs_f, ecs_f);
         check("R2", "fast rd_n", rd_f, ecs_f);
         check("R6", "fast valid", v_f, ev_f);
         check("R7", "fast result", so_f, ed_f);
      end
   end

   // spacing of strobe falls, measured only inside uninterrupted enabled runs
   int last_s = -1, last_f = -1, falls_s = 0, vld_s = 0;
   logic pcs_s = 1, pcs_f = 1;
   always @(negedge clk) begin
      if (rst || !enable) begin
         last_s = -1; last_f = -1;
      end
      if (pcs_s && !cs_s) begin
         falls_s++;
         if (last_s >= 0 && enable && !rst) check("R4", "slow fall spacing", cyc - last_s, SLOW_P);
         if (enable && !rst) last_s = cyc;
      end
      if (pcs_f && !cs_f) begin
         if (last_f >= 0 && enable && !rst) check("R5", "fast fall spacing", cyc - last_f, LOWC + RECOV + 1);
         if (enable && !rst) last_f = cyc;
      end
      if (v_s) vld_s++;
      pcs_s = cs_s; pcs_f = cs_f;
   end

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin : watchdog
      wait_cycles(200000);
      check("R1", "watchdog expired", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stimulus
      int f0, v0;
      rst = 1; enable = 0;
      wait_cycles(4);
      // R1: reset state
      check("R1", "cs_n in reset", cs_s, 1);
      check("R1", "rd_n in reset", rd_s, 1);
      check("R1", "result in reset", so_s, 0);
      check("R1", "valid in reset", v_s, 0);
      armed = 1;
      rst = 0;
      // R8: disabled after reset, ticks discarded
      wait_cycles(100);
      check("R8", "falls while disabled", falls_s, 0);
      // R4 / R5 / R6: periodic running
      enable = 1;
      wait_cycles(400);
      // R8: drop enable in the middle of a low window
      while (cs_s) @(negedge clk);
      wait_cycles(3);
      v0 = vld_s;
      enable = 0;
      wait_cycles(LOWC + 2);
      check("R8", "in-flight cycle delivered", vld_s - v0, 1);
      f0 = falls_s;
      wait_cycles(120);
      check("R8", "no start after disable", falls_s - f0, 0);
      enable = 1;
      wait_cycles(300);
      // R1: reset in the middle of a run restarts the timer
      rst = 1;
      wait_cycles(3);
      check("R1", "cs_n after mid-run reset", cs_s, 1);
      check("R1", "result after mid-run reset", so_s, 0);
      rst = 0;
      wait_cycles(250);
      check("R6", "captures seen", (vld_s > 10) ? 1 : 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule